// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of an on-chip DMA controller. It copies data between one peripheral data port, which sits at a fixed device address, and a memory buffer whose address only counts upward. It moves one packet at a time. Each packet is a read on a simple internal bus master port followed by a write. The channel runs in one of two pacing modes. In firmware-paced mode it moves packets back to back until the buffer end is reached. In peripheral-paced mode it waits for a request from the one peripheral whose device number is bound to the channel, and that peripheral may also cut the transfer short with a terminate line.

When the transfer completes, the go bit clears itself and a sticky done flag raises the channel interrupt. A power controller may ask the channel to sleep. The acknowledge is held back until no transfer is in progress. The channel can also keep a running CRC-32 over every byte it writes, so software can check the data after the transfer.

Top module: `dma_xfer_channel`

## Requirements
- R1: After reset, `go_bit`, `done_irq`, `bus_req` and `sleep_ack` are 0 and `crc_out` is 0xFFFFFFFF.
- R2: No bus cycle is issued unless `go_bit`, `ctl_enable` and `chan_enable` are all 1. A go request is accepted only while `go_bit` is 0, and it loads the memory address from `mem_start`.
- R3: Each packet is one read (`bus_we`=0) followed by one write (`bus_we`=1) of the data just read. With `to_memory`=1 the read goes to `dev_addr` and the write to the memory address. With `to_memory`=0 the read goes to the memory address and the write to `dev_addr`.
- R4: The memory address starts at `mem_start` and advances after each written packet by the packet size. `pkt_sel` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. `bus_size` reports 0, 1 or 2 to match.
- R5: In firmware-paced mode (`hw_paced`=0), the channel stops between packets once the memory address is greater than or equal to `mem_end`. If `mem_start` is greater than or equal to `mem_end`, no packets are moved. On stopping, `go_bit` clears and the channel does not restart by itself.
- R6: In peripheral-paced mode, a packet starts only while `dev_req[dev_id]` is 1. Requests on any other index have no effect.
- R7: In peripheral-paced mode, `dev_term[dev_id]` seen between packets ends the transfer just as reaching the end address does. A packet already under way is completed first, and terminate on any other index has no effect.
- R8: `done_irq` becomes 1 in the same cycle that `go_bit` falls. It stays 1 until a `done_clr` pulse or an accepted go request.
- R9: `sleep_ack` is registered. It becomes 1 one cycle after `sleep_req` is seen while the channel is idle with `go_bit` 0, and it stays 0 whenever `go_bit` is 1.
- R10: With `crc_enable`=1, `crc_out` is updated after each written packet over the packet's bytes, least significant first. The CRC uses the reflected polynomial 0xEDB88320 and is reset to 0xFFFFFFFF when a go request is accepted. With `crc_enable`=0 it keeps its value.
- R11: Once `bus_req` is 1 while `bus_ready` is 0, `bus_req`, `bus_addr` and `bus_we` hold their values on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller-wide enable |
| chan_enable | input | 1 | Channel enable |
| go_set | input | 1 | Pulse requesting a transfer start |
| done_clr | input | 1 | Write-one-to-clear of the done flag |
| mem_start | input | ADDR_W | First memory address |
| mem_end | input | ADDR_W | Terminal memory address (exclusive) |
| dev_addr | input | ADDR_W | Fixed peripheral data address |
| to_memory | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| pkt_sel | input | 2 | Packet size code |
| hw_paced | input | 1 | 1: peripheral-paced, 0: firmware-paced |
| dev_id | input | DEV_W | Bound peripheral number |
| crc_enable | input | 1 | Enable CRC accumulation |
| dev_req | input | 2**DEV_W | Per-peripheral request lines |
| dev_term | input | 2**DEV_W | Per-peripheral terminate lines |
| sleep_req | input | 1 | Sleep request from power control |
| bus_req | output | 1 | Bus cycle valid |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Bus address |
| bus_size | output | 2 | Transfer size code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Bus cycle accepted |
| go_bit | output | 1 | Transfer in progress |
| done_irq | output | 1 | Sticky completion flag and interrupt |
| sleep_ack | output | 1 | Sleep acknowledge |
| crc_out | output | 32 | Running CRC-32 |

## Verification
The bench builds the channel with DEV_W=3 and ADDR_W=16. With eight request and terminate lines, a bench can drive a wrong peripheral number next to the bound one, so the device-select checks are exercised directly. Short addresses keep every buffer in the table to a few dozen packets. This lets the end-address stop, the empty and inverted buffers, and every packet size each finish in a few hundred cycles. A toggling ready pattern on some vectors makes the hold behaviour of the bus and the sleep deferral visible across wait states.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_t;

  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;

  // packet size code to byte count
  function automatic logic [2:0] pkt_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    pkt_bytes = 3'd1;
      2'd1:    pkt_bytes = 3'd2;
      default: pkt_bytes = 3'd4;
    endcase
  endfunction

  // normalised size code reported on the bus
  function automatic logic [1:0] size_code(input logic [1:0] sel);
    size_code = (sel == 2'd3) ? 2'd2 : sel;
  endfunction

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    end
    crc_byte = c;
  endfunction

  function automatic logic [31:0] crc_packet(input logic [31:0] c_in, input logic [31:0] data,
                                             input logic [2:0] nbytes);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < nbytes) c = crc_byte(c, data[8*i +: 8]);
    end
    crc_packet = c;
  endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              advance,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= start_addr;
    end else if (advance) begin
      addr <= addr + ADDR_W'(step);
    end
  end

  assign at_end = (addr >= end_addr);
endmodule

// File: rtl/dma_crc32_acc.sv
module dma_crc32_acc
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        update,
  input  logic [31:0] data,
  input  logic [2:0]  nbytes,
  output logic [31:0] crc
);
  logic [31:0] crc_next;

  always_comb crc_next = crc_packet(crc, data, nbytes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= CRC_SEED;
    end else if (init) begin
      crc <= CRC_SEED;
    end else if (update) begin
      crc <= crc_next;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go_set,
  input  logic        done_clr,
  input  logic        enable,
  input  logic        hw_mode,
  input  logic        sel_req,
  input  logic        sel_term,
  input  logic        at_end,
  input  logic        bus_ready,
  input  logic        sleep_req,
  output xfer_state_t state,
  output logic        go_bit,
  output logic        done,
  output logic        go_acc,
  output logic        stop_now,
  output logic        rd_evt,
  output logic        wr_evt,
  output logic        sleep_ack
);
  logic run, start_pkt;
  xfer_state_t state_nx;

  assign run       = go_bit & enable;
  assign go_acc    = go_set & ~go_bit;
  assign stop_now  = (state == ST_IDLE) && run && (at_end || (hw_mode && sel_term));
  assign start_pkt = (state == ST_IDLE) && run && !stop_now && (!hw_mode || sel_req);
  assign rd_evt    = (state == ST_READ)  && bus_ready;
  assign wr_evt    = (state == ST_WRITE) && bus_ready;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (start_pkt) state_nx = ST_READ;
      ST_READ:  if (bus_ready) state_nx = ST_WRITE;
      ST_WRITE: if (bus_ready) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      go_bit    <= 1'b0;
      done      <= 1'b0;
      sleep_ack <= 1'b0;
    end else begin
      state <= state_nx;
      if (go_acc)        go_bit <= 1'b1;
      else if (stop_now) go_bit <= 1'b0;
      if (stop_now)                done <= 1'b1;
      else if (go_acc || done_clr) done <= 1'b0;
      sleep_ack <= sleep_req && !go_bit && !go_set && (state == ST_IDLE);
    end
  end
endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
  import dma_chan_pkg::*;
#(
  parameter int DEV_W  = 7,
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_enable,
  input  logic                  chan_enable,
  input  logic                  go_set,
  input  logic                  done_clr,
  input  logic [ADDR_W-1:0]     mem_start,
  input  logic [ADDR_W-1:0]     mem_end,
  input  logic [ADDR_W-1:0]     dev_addr,
  input  logic                  to_memory,
  input  logic [1:0]            pkt_sel,
  input  logic                  hw_paced,
  input  logic [DEV_W-1:0]      dev_id,
  input  logic                  crc_enable,
  input  logic [(1<<DEV_W)-1:0] dev_req,
  input  logic [(1<<DEV_W)-1:0] dev_term,
  input  logic                  sleep_req,
  output logic                  bus_req,
  output logic                  bus_we,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [1:0]            bus_size,
  output logic [31:0]           bus_wdata,
  input  logic [31:0]           bus_rdata,
  input  logic                  bus_ready,
  output logic                  go_bit,
  output logic                  done_irq,
  output logic                  sleep_ack,
  output logic [31:0]           crc_out
);
  localparam int NDEV = 1 << DEV_W;

  xfer_state_t       state;
  logic              go_acc, stop_now, rd_evt, wr_evt, done;
  logic              sel_req, sel_term, at_end;
  logic [2:0]        step;
  logic [ADDR_W-1:0] mem_addr, src_addr, dst_addr;
  logic [31:0]       data_q;
  logic [NDEV-1:0]   dev_onehot;

  // one-hot device select, so only the bound peripheral reaches the channel
  genvar gi;
  generate
    for (gi = 0; gi < NDEV; gi++) begin : g_sel
      assign dev_onehot[gi] = (dev_id == DEV_W'(gi));
    end
  endgenerate

  assign sel_req  = |(dev_req  & dev_onehot);
  assign sel_term = |(dev_term & dev_onehot);
  assign step     = pkt_bytes(pkt_sel);

  dma_chan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_set(go_set), .done_clr(done_clr),
    .enable(ctl_enable & chan_enable), .hw_mode(hw_paced),
    .sel_req(sel_req), .sel_term(sel_term), .at_end(at_end),
    .bus_ready(bus_ready), .sleep_req(sleep_req), .state(state),
    .go_bit(go_bit), .done(done), .go_acc(go_acc), .stop_now(stop_now),
    .rd_evt(rd_evt), .wr_evt(wr_evt), .sleep_ack(sleep_ack)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(go_acc), .start_addr(mem_start),
    .advance(wr_evt), .step(step), .end_addr(mem_end),
    .addr(mem_addr), .at_end(at_end)
  );

  dma_crc32_acc u_crc (
    .clk(clk), .rst_n(rst_n), .init(go_acc), .update(wr_evt & crc_enable),
    .data(data_q), .nbytes(step), .crc(crc_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (rd_evt) data_q <= bus_rdata;
  end

  assign src_addr  = to_memory ? dev_addr : mem_addr;
  assign dst_addr  = to_memory ? mem_addr : dev_addr;
  assign bus_req   = (state != ST_IDLE);
  assign bus_we    = (state == ST_WRITE);
  assign bus_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
  assign bus_size  = size_code(pkt_sel);
  assign bus_wdata = data_q;
  assign done_irq  = done;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go_bit,
  input logic              go_set,
  input logic              done_irq,
  input logic              done_clr,
  input logic              bus_req,
  input logic              bus_ready,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              sleep_ack,
  input logic              wr_evt,
  input logic [31:0]       crc_out
);
  AST_NO_BUS_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !go_bit |-> !bus_req); // R2

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R11

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> !bus_req); // R9

  AST_SLEEP_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go_bit |=> (!sleep_ack || !$past(go_bit))); // R9

  AST_DONE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_bit) |-> done_irq); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq && !done_clr && !go_set) |=> done_irq); // R8

  AST_CRC_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !(go_set && !go_bit)) |=> $stable(crc_out)); // R10
endmodule

bind dma_xfer_channel dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_bit(go_bit), .go_set(go_set),
  .done_irq(done_irq), .done_clr(done_clr), .bus_req(bus_req),
  .bus_ready(bus_ready), .bus_we(bus_we), .bus_addr(bus_addr),
  .sleep_ack(sleep_ack), .wr_evt(wr_evt), .crc_out(crc_out)
);

// File: tb/sim_dma_xfer_channel.sv
module sim_dma_xfer_channel;
  localparam int DEV_W  = 3;
  localparam int ADDR_W = 16;
  localparam int NDEV   = 1 << DEV_W;
  localparam logic [ADDR_W-1:0] DEVA = 16'hF000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_enable = 1'b1, chan_enable = 1'b1, go_set = 1'b0, done_clr = 1'b0;
  logic [ADDR_W-1:0] mem_start = '0, mem_end = '0;
  logic to_memory = 1'b1, hw_paced = 1'b0, crc_enable = 1'b0, sleep_req = 1'b0;
  logic [1:0] pkt_sel = 2'd0;
  logic [DEV_W-1:0] dev_id = '0;
  logic [NDEV-1:0] dev_req = '0, dev_term = '0;
  logic bus_req, bus_we, bus_ready, go_bit, done_irq, sleep_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata, crc_out;

  always #10 clk = ~clk;  // 50 MHz

  dma_xfer_channel #(.DEV_W(DEV_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .chan_enable(chan_enable),
    .go_set(go_set), .done_clr(done_clr), .mem_start(mem_start), .mem_end(mem_end),
    .dev_addr(DEVA), .to_memory(to_memory), .pkt_sel(pkt_sel), .hw_paced(hw_paced),
    .dev_id(dev_id), .crc_enable(crc_enable), .dev_req(dev_req), .dev_term(dev_term),
    .sleep_req(sleep_req), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .go_bit(go_bit), .done_irq(done_irq),
    .sleep_ack(sleep_ack), .crc_out(crc_out)
  );

  int checks = 0, errors = 0;

  // bus model
  logic stall_mode = 1'b0, stall_tgl = 1'b0;
  logic [31:0] rd_cnt = 0;
  assign bus_ready = !stall_mode || stall_tgl;
  always_comb bus_rdata = {bus_addr, bus_addr ^ 16'h5A5A} + rd_cnt;

  // scoreboard of writes
  int wr_n = 0, rd_n = 0, addr_err = 0, data_err = 0;
  logic [31:0] crc_ref = 32'hFFFF_FFFF, last_rd = 0;
  int step_b = 1;

  function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [31:0] d, input int nb);
    logic [31:0] c = c_in;
    for (int k = 0; k < 8*nb; k++) begin
      logic fb = c[0] ^ d[k];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    stall_tgl <= ~stall_tgl;
    if (go_set && !go_bit) begin
      crc_ref = 32'hFFFF_FFFF; wr_n = 0; rd_n = 0; addr_err = 0; data_err = 0;
      step_b = (pkt_sel == 2'd0) ? 1 : (pkt_sel == 2'd1) ? 2 : 4;
    end else if (bus_req && bus_ready) begin
      logic [ADDR_W-1:0] m_exp;
      m_exp = mem_start + ADDR_W'(wr_n * step_b);
      if (!bus_we) begin
        if (bus_addr !== (to_memory ? DEVA : m_exp)) addr_err++;
        if (rd_n != wr_n) addr_err++;
        last_rd = bus_rdata; rd_n++; rd_cnt <= rd_cnt + 1;
      end else begin
        if (bus_addr !== (to_memory ? m_exp : DEVA)) addr_err++;
        if (bus_wdata !== last_rd) data_err++;
        if (bus_size !== ((pkt_sel == 2'd3) ? 2'd2 : pkt_sel)) addr_err++;
        if (crc_enable) crc_ref = ref_crc(crc_ref, bus_wdata, step_b);
        wr_n++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_go();
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done_irq; i++) @(negedge clk);
  endtask

  // {start, end, pkt_sel, to_memory, crc_enable, packets}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {16'h0100, 16'h0110, 2'd2, 1'b1, 1'b1, 8'd4},
    {16'h0200, 16'h0207, 2'd0, 1'b0, 1'b1, 8'd7},
    {16'h0300, 16'h0305, 2'd1, 1'b1, 1'b1, 8'd3},
    {16'h0400, 16'h0400, 2'd2, 1'b1, 1'b1, 8'd0},
    {16'h0500, 16'h04F0, 2'd0, 1'b1, 1'b1, 8'd0},
    {16'h0600, 16'h0608, 2'd3, 1'b0, 1'b0, 8'd2},
    {16'h0700, 16'h0720, 2'd2, 1'b0, 1'b1, 8'd8}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 go_bit", 32'(go_bit), 0);
    chk("R1 done", 32'(done_irq), 0);
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 sleep_ack", 32'(sleep_ack), 0);
    chk("R1 crc", crc_out, 32'hFFFF_FFFF);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: firmware-paced, R3 R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      mem_start = VEC[v][43:28]; mem_end = VEC[v][27:12];
      pkt_sel = VEC[v][11:10]; to_memory = VEC[v][9]; crc_enable = VEC[v][8];
      stall_mode = v[0];
      pulse_go();
      wait_done();
      @(negedge clk);
      chk("R5 packet count", 32'(wr_n), 32'(VEC[v][7:0]));
      chk("R4 R3 address/direction/size", 32'(addr_err), 0);
      chk("R3 data copied", 32'(data_err), 0);
      chk("R10 crc", crc_out, crc_ref);
      chk("R8 done set", 32'(done_irq), 1);
      chk("R5 go cleared", 32'(go_bit), 0);
      repeat (8) @(negedge clk);
      chk("R5 no restart", 32'(wr_n), 32'(VEC[v][7:0]));
    end
    stall_mode = 1'b0;

    // R8 done write-one clear
    @(negedge clk) done_clr = 1'b1;
    @(negedge clk) done_clr = 1'b0;
    chk("R8 done_clr", 32'(done_irq), 0);

    // R9 idle sleep ack one cycle later
    @(negedge clk) sleep_req = 1'b1;
    @(negedge clk);
    chk("R9 idle ack", 32'(sleep_ack), 1);

    // R2 channel disabled: no motion, R9 ack withheld
    chan_enable = 1'b0; mem_start = 16'h0800; mem_end = 16'h0810; pkt_sel = 2'd2;
    to_memory = 1'b1; crc_enable = 1'b1;
    pulse_go();
    repeat (20) @(negedge clk);
    chk("R2 no writes while disabled", 32'(wr_n), 0);
    chk("R9 ack low while go", 32'(sleep_ack), 0);
    chan_enable = 1'b1;
    wait_done();
    chk("R2 runs once enabled", 32'(wr_n), 4);
    repeat (2) @(negedge clk);
    chk("R9 ack after finish", 32'(sleep_ack), 1);
    sleep_req = 1'b0;

    // R9 sleep deferral during a long stalled transfer
    stall_mode = 1'b1; mem_start = 16'h0900; mem_end = 16'h0940; pkt_sel = 2'd0;
    pulse_go();
    repeat (5) @(negedge clk);
    sleep_req = 1'b1;
    begin
      int early = 0;
      while (go_bit) begin
        if (sleep_ack) early++;
        @(negedge clk);
      end
      chk("R9 no ack during transfer", 32'(early), 0);
    end
    chk("R5 deferred transfer complete", 32'(wr_n), 64);
    @(negedge clk);
    chk("R9 ack once finished", 32'(sleep_ack), 1);
    sleep_req = 1'b0; stall_mode = 1'b0;

    // R6 R7 peripheral-paced, bound device 5
    hw_paced = 1'b1; dev_id = 3'd5; mem_start = 16'h0A00; mem_end = 16'h0A40; pkt_sel = 2'd2;
    pulse_go();
    repeat (10) @(negedge clk);
    chk("R6 waits for request", 32'(wr_n), 0);
    dev_req[2] = 1'b1; dev_term[2] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 other request ignored", 32'(wr_n), 0);
    chk("R7 other terminate ignored", 32'(go_bit), 1);
    dev_req[2] = 1'b0; dev_term[2] = 1'b0;
    dev_req[5] = 1'b1;
    for (int i = 0; i < 200 && wr_n < 3; i++) @(negedge clk);
    dev_req[5] = 1'b0;
    repeat (10) @(negedge clk);
    chk("R6 paced packets", 32'(wr_n), 3);
    chk("R7 still running", 32'(go_bit), 1);
    dev_term[5] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 terminate stops", 32'(go_bit), 0);
    chk("R8 done on terminate", 32'(done_irq), 1);
    chk("R4 addresses paced", 32'(addr_err), 0);
    dev_term[5] = 1'b0;

    // R8 accepted go clears done; R5 empty buffer re-sets it
    hw_paced = 1'b0; mem_start = 16'h0B00; mem_end = 16'h0B00;
    pulse_go();
    chk("R8 go clears done", 32'(done_irq), 0);
    @(negedge clk);
    chk("R5 empty buffer done", 32'(done_irq), 1);
    chk("R5 empty buffer no packets", 32'(wr_n), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule